// File: doc/BRIEF.md
# Clock Source Warmup and Divider Controller

This block produces the system clock enable for a small controller. It works from two oscillator domains, each modelled as a one-cycle tick on the fast sampling clock: an internal FLL and an external crystal. Any time the crystal has to start again, which happens after reset, after a wake from stop, or when software first asks for it, the block counts a fixed number of crystal oscillations before it trusts the crystal. During that count the system keeps running from the FLL. When the count completes, the block moves onto the crystal without any software action. The FLL can also use the crystal as its reference. In that case the crystal has to warm up in the same way, but the system enables still come from the FLL.

A divider sits after the source selection. It passes one enable for every 1, 2, 4 or 8 source ticks. A power-management mode slows this to one enable per 256 source ticks. A new divide setting is loaded only at the end of the current divided period, so no enable period is ever cut short. When switchback is allowed, an external interrupt or serial activity drops power-management mode at once and restarts the divider at the full-speed setting. A stop request halts all enables until a wake event arrives.

The state machine has four states. FLL_ONLY means the crystal is not in use. WARM means the crystal is warming up and the FLL supplies the enables. READY means the crystal is stable. STOP means everything is halted. Its transitions are:
- stop: any running state goes to STOP on `stop_req`.
- wake: STOP goes to WARM on `wake` when the crystal is needed, and to FLL_ONLY otherwise.
- start: FLL_ONLY goes to WARM when the crystal becomes needed.
- done: WARM goes to READY on the crystal tick that completes the count.
- release: WARM or READY goes to FLL_ONLY when the crystal is no longer needed.

Stop has priority over every other transition.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, `warming`, `xtal_active`, `pmm_active` and `stopped` are all 0, and the divider is at divide-by-1.
- R2: The crystal is needed when `xtal_sel` or `fll_on_xtal` is 1. While the crystal is warming up:
  - `warming` is 1.
  - Enables follow `fll_tick` only.
  - Crystal ticks are counted.

  One cycle after the tick that completes the count of WARM_CYCLES crystal ticks, `warming` is 0. If `xtal_sel`=1 at that point, `xtal_active` is 1 and enables follow `xtal_tick` only.
- R3: A `stop_req` pulse sets `stopped` one cycle later. While `stopped` is 1, no `sys_clk_en` is produced, whatever ticks arrive.
- R4: A `wake` pulse while stopped, with the crystal needed, restarts the warmup count from zero. A warmup that was cut short by stop therefore needs the full WARM_CYCLES again.
- R5: `div_sel` codes 00, 01, 10 and 11 give one enable per 1, 2, 4 and 8 source ticks. An enable only ever coincides with a source tick.
- R6: While power-management mode is in effect, there is one enable per 256 source ticks. The mode is set by a `pmm_enter` pulse and cleared by a `pmm_leave` pulse.
- R7: With `sb_en`=1, an `ext_irq` or `serial_act` pulse during power-management mode clears `pmm_active` one cycle later. It also restarts the divider at the `div_sel` ratio, so with `div_sel`=00 the next source tick gives an enable. With `sb_en`=0, these pulses have no effect.
- R8: A change of divide setting takes effect only after the enable that ends the current period. That period keeps its old length.
- R9: With `fll_on_xtal`=1 and `xtal_sel`=0, the warmup still runs and `warming` behaves as in R2. `xtal_active` stays 0, and enables follow `fll_tick` both during and after the warmup.
- R10: When neither `xtal_sel` nor `fll_on_xtal` is 1, the block returns from warmup or from the crystal to the FLL one cycle later. `warming` and `xtal_active` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fll_tick | input | 1 | One tick per internal FLL oscillation |
| xtal_tick | input | 1 | One tick per crystal oscillation |
| xtal_sel | input | 1 | Run the system from the crystal |
| fll_on_xtal | input | 1 | FLL uses the crystal as reference |
| div_sel | input | 2 | Divide code: 00=1, 01=2, 10=4, 11=8 |
| pmm_enter | input | 1 | Pulse: enter power-management mode |
| pmm_leave | input | 1 | Pulse: leave power-management mode |
| sb_en | input | 1 | Allow hardware switchback |
| ext_irq | input | 1 | External interrupt event |
| serial_act | input | 1 | Serial port activity event |
| stop_req | input | 1 | Pulse: enter stop |
| wake | input | 1 | Pulse: leave stop |
| sys_clk_en | output | 1 | System clock enable |
| warming | output | 1 | Crystal warmup in progress |
| xtal_active | output | 1 | System runs from the crystal |
| pmm_active | output | 1 | Power-management mode in effect |
| stopped | output | 1 | Stop mode, no enables |

## Verification
The hardest case to reach is a warmup that a stop interrupts partway through. Showing that the count really starts again requires crystal ticks that stop short of completion, then a stop, then a wake, then a second partial run. The bench brings the block to READY once, stops it, and wakes it. It then gives 10 of the 16 warmup ticks and stops again. After the next wake it checks that `warming` is still set after 10 more ticks, a total of 20. The move to the crystal must come only after 16 ticks since the last wake. The switchback case is set up in a similar way: the bench first places the divider in the middle of a 256-tick period, then delivers the wake events with switchback disabled and afterwards with it enabled.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        S_FLL_ONLY = 2'd0,
        S_WARM     = 2'd1,
        S_READY    = 2'd2,
        S_STOP     = 2'd3
    } src_state_e;

    // divider ratio codes: 0..3 are 2**code, PMM_CODE selects the slow mode
    localparam logic [2:0] PMM_CODE = 3'd4;

endpackage

// File: rtl/clk_warm_fsm.sv
module clk_warm_fsm
    import clk_src_pkg::*;
#(
    parameter int unsigned WARM_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic need_xtal,
    input  logic stop_req,
    input  logic wake,
    output logic warming,
    output logic ready,
    output logic stopped
);

    localparam int unsigned WW = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WARM_CYCLES - 1);

    src_state_e state, state_nx;
    logic [WW-1:0] wcnt;
    logic warm_done;

    assign warm_done = xtal_tick && (wcnt == WLAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FLL_ONLY: begin
                if (stop_req)       state_nx = S_STOP;
                else if (need_xtal) state_nx = S_WARM;
            end
            S_WARM: begin
                if (stop_req)        state_nx = S_STOP;
                else if (!need_xtal) state_nx = S_FLL_ONLY;
                else if (warm_done)  state_nx = S_READY;
            end
            S_READY: begin
                if (stop_req)        state_nx = S_STOP;
                else if (!need_xtal) state_nx = S_FLL_ONLY;
            end
            S_STOP: begin
                if (wake) state_nx = need_xtal ? S_WARM : S_FLL_ONLY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_FLL_ONLY;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == S_WARM && state_nx == S_WARM) begin
                if (xtal_tick) wcnt <= wcnt + 1'b1;
            end else begin
                wcnt <= '0;
            end
        end
    end

    always_comb begin
        warming = 1'b0;
        ready   = 1'b0;
        stopped = 1'b0;
        unique case (state)
            S_FLL_ONLY: ;
            S_WARM:     warming = 1'b1;
            S_READY:    ready   = 1'b1;
            S_STOP:     stopped = 1'b1;
        endcase
    end

endmodule

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
    import clk_src_pkg::*;
#(
    parameter int unsigned PMM_RATIO = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_tick,
    input  logic [1:0] div_sel,
    input  logic       pmm_enter,
    input  logic       pmm_leave,
    input  logic       sb_en,
    input  logic       wake_evt,
    output logic       sys_clk_en,
    output logic       pmm_active
);

    localparam int unsigned CW = $clog2(PMM_RATIO);

    logic [2:0]    code, req_code;
    logic [CW-1:0] cnt, last;
    logic          switchback;

    assign switchback = sb_en && wake_evt && pmm_active;
    assign req_code   = pmm_active ? PMM_CODE : {1'b0, div_sel};

    always_comb begin
        if (code == PMM_CODE) last = CW'(PMM_RATIO - 1);
        else                  last = CW'((1 << code[1:0]) - 1);
    end

    assign sys_clk_en = src_tick && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmm_active <= 1'b0;
            code       <= 3'd0;
            cnt        <= '0;
        end else begin
            if (switchback)     pmm_active <= 1'b0;
            else if (pmm_enter) pmm_active <= 1'b1;
            else if (pmm_leave) pmm_active <= 1'b0;

            if (switchback) begin
                cnt  <= '0;
                code <= {1'b0, div_sel};
            end else if (sys_clk_en) begin
                cnt  <= '0;
                code <= req_code;
            end else if (src_tick) begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int unsigned WARM_CYCLES = 65536,
    parameter int unsigned PMM_RATIO   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fll_tick,
    input  logic       xtal_tick,
    input  logic       xtal_sel,
    input  logic       fll_on_xtal,
    input  logic [1:0] div_sel,
    input  logic       pmm_enter,
    input  logic       pmm_leave,
    input  logic       sb_en,
    input  logic       ext_irq,
    input  logic       serial_act,
    input  logic       stop_req,
    input  logic       wake,
    output logic       sys_clk_en,
    output logic       warming,
    output logic       xtal_active,
    output logic       pmm_active,
    output logic       stopped
);

    logic need_xtal, ready, src_tick;

    assign need_xtal = xtal_sel || fll_on_xtal;

    clk_warm_fsm #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .need_xtal (need_xtal),
        .stop_req  (stop_req),
        .wake      (wake),
        .warming   (warming),
        .ready     (ready),
        .stopped   (stopped)
    );

    assign xtal_active = ready && xtal_sel;
    assign src_tick    = stopped ? 1'b0 : (xtal_active ? xtal_tick : fll_tick);

    clk_div_ctrl #(.PMM_RATIO(PMM_RATIO)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick   (src_tick),
        .div_sel    (div_sel),
        .pmm_enter  (pmm_enter),
        .pmm_leave  (pmm_leave),
        .sb_en      (sb_en),
        .wake_evt   (ext_irq || serial_act),
        .sys_clk_en (sys_clk_en),
        .pmm_active (pmm_active)
    );

endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fll_tick,
    input logic xtal_tick,
    input logic xtal_sel,
    input logic fll_on_xtal,
    input logic sb_en,
    input logic ext_irq,
    input logic serial_act,
    input logic stop_req,
    input logic wake,
    input logic sys_clk_en,
    input logic warming,
    input logic xtal_active,
    input logic pmm_active,
    input logic stopped
);

    // R3
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !sys_clk_en);

    // R3
    stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !stopped) |=> stopped);

    // R2
    warm_on_fll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warming && !fll_tick) |-> !sys_clk_en);

    // R2
    xtal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_active && !xtal_tick) |-> !sys_clk_en);

    // R4
    wake_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wake && (xtal_sel || fll_on_xtal)) |=> warming);

    // R7
    switchback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_active && sb_en && (ext_irq || serial_act)) |=> !pmm_active);

    // R5
    en_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_en |-> (fll_tick || xtal_tick));

    // R2
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warming, xtal_active, stopped}));

endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fll_tick    (fll_tick),
    .xtal_tick   (xtal_tick),
    .xtal_sel    (xtal_sel),
    .fll_on_xtal (fll_on_xtal),
    .sb_en       (sb_en),
    .ext_irq     (ext_irq),
    .serial_act  (serial_act),
    .stop_req    (stop_req),
    .wake        (wake),
    .sys_clk_en  (sys_clk_en),
    .warming     (warming),
    .xtal_active (xtal_active),
    .pmm_active  (pmm_active),
    .stopped     (stopped)
);

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;

    localparam int WARM = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fll_tick = 0, xtal_tick = 0, xtal_sel = 0, fll_on_xtal = 0;
    logic [1:0] div_sel = 2'd0;
    logic pmm_enter = 0, pmm_leave = 0, sb_en = 0, ext_irq = 0, serial_act = 0;
    logic stop_req = 0, wake = 0;
    logic sys_clk_en, warming, xtal_active, pmm_active, stopped;

    logic p_enter = 0, p_leave = 0, p_irq = 0, p_ser = 0, p_stop = 0, p_wake = 0;
    logic last_en;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clk_src_ctrl #(.WARM_CYCLES(WARM), .PMM_RATIO(256)) u0 (
        .clk(clk), .rst_n(rst_n), .fll_tick(fll_tick), .xtal_tick(xtal_tick),
        .xtal_sel(xtal_sel), .fll_on_xtal(fll_on_xtal), .div_sel(div_sel),
        .pmm_enter(pmm_enter), .pmm_leave(pmm_leave), .sb_en(sb_en),
        .ext_irq(ext_irq), .serial_act(serial_act), .stop_req(stop_req),
        .wake(wake), .sys_clk_en(sys_clk_en), .warming(warming),
        .xtal_active(xtal_active), .pmm_active(pmm_active), .stopped(stopped)
    );

    // {div_sel, pmm, expected source ticks per enable}
    typedef struct packed { logic [1:0] sel; logic pmm; logic [15:0] ratio; } vec_t;
    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 16'd1}, '{2'd1, 1'b0, 16'd2}, '{2'd2, 1'b0, 16'd4},
        '{2'd3, 1'b0, 16'd8}, '{2'd1, 1'b1, 16'd256}, '{2'd0, 1'b0, 16'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic x);
        @(negedge clk);
        fll_tick = f; xtal_tick = x;
        pmm_enter = p_enter; pmm_leave = p_leave; ext_irq = p_irq;
        serial_act = p_ser; stop_req = p_stop; wake = p_wake;
        p_enter = 0; p_leave = 0; p_irq = 0; p_ser = 0; p_stop = 0; p_wake = 0;
        #1;
        last_en = sys_clk_en;
    endtask

    task automatic run_until_en(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            step(1'b1, 1'b0);
            n++;
            if (last_en) break;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        int n, ens;
        logic prev_pmm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check({warming, xtal_active, pmm_active, stopped} == 4'b0, "R1 flags",
              {warming, xtal_active, pmm_active, stopped}, 0);
        step(1, 0);
        check(last_en == 1, "R1 div1 after reset", last_en, 1);

        // R5 / R6 table walk
        prev_pmm = 0;
        foreach (VECS[i]) begin
            div_sel = VECS[i].sel;
            if (VECS[i].pmm && !prev_pmm) p_enter = 1;
            if (!VECS[i].pmm && prev_pmm) p_leave = 1;
            prev_pmm = VECS[i].pmm;
            step(0, 0);
            run_until_en(n);
            run_until_en(n);
            run_until_en(n);
            check(n == int'(VECS[i].ratio), VECS[i].pmm ? "R6 pmm period" : "R5 divide period",
                  n, VECS[i].ratio);
        end

        // R8 change mid-period
        div_sel = 2'd3;
        run_until_en(n);
        run_until_en(n);
        for (int i = 0; i < 3; i++) step(1, 0);
        div_sel = 2'd0;
        run_until_en(n);
        check(n == 5, "R8 old period kept", n, 5);
        run_until_en(n);
        check(n == 1, "R8 new period", n, 1);

        // R7 switchback
        p_enter = 1;
        step(0, 0);
        run_until_en(n);
        run_until_en(n);
        for (int i = 0; i < 10; i++) step(1, 0);
        sb_en = 0; p_irq = 1;
        step(0, 0);
        step(0, 0);
        check(pmm_active == 1, "R7 ignored without sb_en", pmm_active, 1);
        run_until_en(n);
        check(n == 246, "R7 period unaffected", n, 246);
        for (int i = 0; i < 5; i++) step(1, 0);
        sb_en = 1; p_ser = 1;
        step(0, 0);
        step(1, 0);
        check(pmm_active == 0, "R7 pmm cleared", pmm_active, 0);
        check(last_en == 1, "R7 immediate full speed", last_en, 1);
        sb_en = 0;

        // R2 warmup
        xtal_sel = 1;
        step(0, 0);
        step(1, 0);
        check(warming == 1, "R2 warming set", warming, 1);
        check(last_en == 1, "R2 fll drives during warmup", last_en, 1);
        ens = 0;
        for (int i = 0; i < WARM - 1; i++) begin step(0, 1); ens += int'(last_en); end
        check(ens == 0, "R2 xtal ignored while warming", ens, 0);
        check(warming == 1, "R2 still warming before count", warming, 1);
        step(0, 1);
        step(0, 0);
        check(warming == 0 && xtal_active == 1, "R2 switched to crystal",
              {warming, xtal_active}, 1);
        step(1, 0);
        check(last_en == 0, "R2 fll ignored on crystal", last_en, 0);
        step(0, 1);
        check(last_en == 1, "R2 crystal drives", last_en, 1);

        // R3 stop
        p_stop = 1;
        step(0, 0);
        ens = 0;
        for (int i = 0; i < 5; i++) begin step(1, 1); ens += int'(last_en); end
        check(stopped == 1, "R3 stopped", stopped, 1);
        check(ens == 0, "R3 no enables in stop", ens, 0);

        // R4 wake restarts warmup, also after an interrupted warmup
        p_wake = 1;
        step(0, 0);
        step(0, 0);
        check(warming == 1 && stopped == 0, "R4 warmup after wake", {warming, stopped}, 2);
        for (int i = 0; i < 10; i++) step(0, 1);
        p_stop = 1;
        step(0, 0);
        p_wake = 1;
        step(0, 0);
        for (int i = 0; i < 10; i++) step(0, 1);
        step(0, 0);
        check(warming == 1, "R4 count restarted", warming, 1);
        for (int i = 0; i < WARM - 10; i++) step(0, 1);
        step(0, 0);
        check(warming == 0 && xtal_active == 1, "R4 ready after full count",
              {warming, xtal_active}, 1);

        // R10 release crystal
        xtal_sel = 0;
        step(0, 0);
        step(1, 0);
        check(warming == 0 && xtal_active == 0, "R10 back on fll", {warming, xtal_active}, 0);
        check(last_en == 1, "R10 fll drives", last_en, 1);

        // R9 fll referenced to crystal
        fll_on_xtal = 1;
        step(0, 0);
        step(0, 0);
        check(warming == 1, "R9 warmup runs", warming, 1);
        for (int i = 0; i < WARM; i++) step(0, 1);
        step(0, 0);
        check(warming == 0 && xtal_active == 0, "R9 done, not on crystal",
              {warming, xtal_active}, 0);
        step(0, 1);
        check(last_en == 0, "R9 crystal tick ignored", last_en, 0);
        step(1, 0);
        check(last_en == 1, "R9 fll drives", last_en, 1);

        done = 1;
        summary();
    end

endmodule